// File: doc/BRIEF.md
# Synchronize Mode-Code Time-Tag Loader

This block sits inside a MIL-STD-1553 remote terminal. It owns a 16-bit time-tag counter and decides how that counter reacts when a valid "synchronize with data word" mode command (mode code 17) is received. The counter advances on a free-running tick enable. A 2-bit configuration field selects how the data word that follows the command is treated: it can be ignored and left to the host, loaded always, or loaded only when its least significant bit has a chosen value.

Upstream logic presents a decoded command strobe with a broadcast flag. It then presents a data-word strobe with an error flag and the 16-bit word. Every valid synchronize command produces a one-cycle host notification. For a non-broadcast command, the block also emits a one-cycle status-release pulse. That pulse lets the status-word encoder transmit, and it never precedes the counter load. A broadcast command gets no status release.

Top module: `sync_tt_loader`

## Requirements
- R1: The option field resets to 00 and takes the value on `cfg_opt` in the cycle after a clock edge where `cfg_wr` is high; it holds otherwise.
- R2: With option 11, a valid synchronize data word is always loaded into the time-tag counter.
- R3: With option 01, the data word is loaded only when its bit 0 is 0.
- R4: With option 10, the data word is loaded only when its bit 0 is 1.
- R5: With option 00, no load occurs, yet the host notification and (for non-broadcast) the status release still occur.
- R6: For a non-broadcast command, the status release pulses in the cycle after the load cycle; with no load it pulses in the cycle after validation. The loaded value is visible on `tt_count` no later than the release.
- R7: For a broadcast command, the status release never pulses; a load, when enabled, happens in the cycle after validation.
- R8: A data word presented with `dw_err` high causes no load, no notification and no release.
- R9: `host_note` is a single-cycle pulse in the cycle after validation of every valid synchronize command.
- R10: `tt_count` increments by one on each cycle with `tick` high and wraps from 0xFFFF to 0x0000; it holds when neither tick nor load occurs.
- R11: A load in the same cycle as a tick wins over the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the option field |
| cfg_opt | input | 2 | New option value: 00 host, 01 load if bit0=0, 10 load if bit0=1, 11 always load |
| cmd_stb | input | 1 | Valid synchronize-with-data command decoded |
| cmd_bcast | input | 1 | Command was broadcast (qualified by `cmd_stb`) |
| dw_stb | input | 1 | Data word received |
| dw_err | input | 1 | Data word failed validation (qualified by `dw_stb`) |
| dw_data | input | 16 | Received data word |
| tick | input | 1 | Time-tag increment enable |
| tt_count | output | 16 | Time-tag counter value |
| host_note | output | 1 | One-cycle host notification of a synchronize command |
| stat_release | output | 1 | One-cycle permission to transmit the status word |

## Verification
A wrong control state shows within two cycles of the data-word strobe. If the release pulse fires one cycle early, or `host_note` appears for a rejected word, either is seen at the port in the very next cycle. A wrong load decision or a lost load shows on `tt_count` two cycles after the data word. That value persists until the next load, so a counter that stays fixed between commands exposes it at every later sample. Wrap and tick-versus-load priority errors show one cycle after the offending edge.

// File: rtl/sync_tt_pkg.sv
package sync_tt_pkg;

    localparam int TT_W   = 16;
    localparam int OPT_W  = 2;

    typedef enum logic [OPT_W-1:0] {
        SYNC_OPT_HOST    = 2'b00,
        SYNC_OPT_B0_LOW  = 2'b01,
        SYNC_OPT_B0_HIGH = 2'b10,
        SYNC_OPT_ALWAYS  = 2'b11
    } sync_opt_e;

    typedef enum logic [1:0] {
        CT_IDLE    = 2'b00,
        CT_WAIT_DW = 2'b01,
        CT_LOAD    = 2'b10
    } ctrl_state_e;

    // Decide whether the received word must go into the counter
    function automatic logic sync_load_needed(input sync_opt_e opt, input logic lsb);
        case (opt)
            SYNC_OPT_ALWAYS:  sync_load_needed = 1'b1;
            SYNC_OPT_B0_LOW:  sync_load_needed = ~lsb;
            SYNC_OPT_B0_HIGH: sync_load_needed = lsb;
            default:          sync_load_needed = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sync_tt_cfg.sv
module sync_tt_cfg
    import sync_tt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [OPT_W-1:0] cfg_opt,
    output sync_opt_e        opt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            opt <= SYNC_OPT_HOST;
        end else if (cfg_wr) begin
            opt <= sync_opt_e'(cfg_opt);
        end
    end

    AST_OPT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(opt)); // R1

endmodule

// File: rtl/sync_tt_ctrl.sv
module sync_tt_ctrl
    import sync_tt_pkg::*;
#(
    parameter int W = TT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  sync_opt_e    opt,
    input  logic         cmd_stb,
    input  logic         cmd_bcast,
    input  logic         dw_stb,
    input  logic         dw_err,
    input  logic [W-1:0] dw_data,
    output logic         load_en,
    output logic [W-1:0] load_data,
    output logic         host_note,
    output logic         stat_rel
);

    ctrl_state_e state;
    logic        bcast_q;
    logic        want_load;

    assign want_load = sync_load_needed(opt, dw_data[0]);
    assign load_en   = (state == CT_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= CT_IDLE;
            bcast_q   <= 1'b0;
            load_data <= '0;
            host_note <= 1'b0;
            stat_rel  <= 1'b0;
        end else begin
            host_note <= 1'b0;
            stat_rel  <= 1'b0;
            case (state)
                CT_IDLE: begin
                    if (cmd_stb) begin
                        state   <= CT_WAIT_DW;
                        bcast_q <= cmd_bcast;
                    end
                end
                CT_WAIT_DW: begin
                    if (dw_stb) begin
                        if (dw_err) begin
                            state <= CT_IDLE;
                        end else begin
                            host_note <= 1'b1;
                            if (want_load) begin
                                state     <= CT_LOAD;
                                load_data <= dw_data;
                            end else begin
                                state    <= CT_IDLE;
                                stat_rel <= ~bcast_q;
                            end
                        end
                    end else if (cmd_stb) begin
                        bcast_q <= cmd_bcast;
                    end
                end
                CT_LOAD: begin
                    stat_rel <= ~bcast_q;
                    if (cmd_stb) begin
                        state   <= CT_WAIT_DW;
                        bcast_q <= cmd_bcast;
                    end else begin
                        state <= CT_IDLE;
                    end
                end
                default: state <= CT_IDLE;
            endcase
        end
    end

    AST_NOTE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        host_note |=> !host_note); // R9
    AST_LOAD_THEN_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (load_en && !bcast_q) |=> stat_rel); // R6
    AST_BCAST_SILENT: assert property (@(posedge clk) disable iff (rst)
        (load_en && bcast_q) |=> !stat_rel); // R7
    AST_ERR_NO_NOTE: assert property (@(posedge clk) disable iff (rst)
        (dw_stb && dw_err) |=> (!host_note && !load_en)); // R8
    AST_LOAD_HAS_NOTE: assert property (@(posedge clk) disable iff (rst)
        load_en |-> host_note); // R9

endmodule

// File: rtl/sync_tt_counter.sv
module sync_tt_counter
    import sync_tt_pkg::*;
#(
    parameter int W = TT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load_en,
    input  logic [W-1:0] load_data,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load_en) begin
            count <= load_data;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (count == $past(load_data))); // R11
    AST_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!load_en && tick && count == CNT_MAX) |=> (count == '0)); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !tick) |=> $stable(count)); // R10

endmodule

// File: rtl/sync_tt_loader.sv
module sync_tt_loader
    import sync_tt_pkg::*;
#(
    parameter int W = TT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [OPT_W-1:0] cfg_opt,
    input  logic             cmd_stb,
    input  logic             cmd_bcast,
    input  logic             dw_stb,
    input  logic             dw_err,
    input  logic [W-1:0]     dw_data,
    input  logic             tick,
    output logic [W-1:0]     tt_count,
    output logic             host_note,
    output logic             stat_release
);

    sync_opt_e    opt;
    logic         load_en;
    logic [W-1:0] load_data;

    sync_tt_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cfg_wr  (cfg_wr),
        .cfg_opt (cfg_opt),
        .opt     (opt)
    );

    sync_tt_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .opt       (opt),
        .cmd_stb   (cmd_stb),
        .cmd_bcast (cmd_bcast),
        .dw_stb    (dw_stb),
        .dw_err    (dw_err),
        .dw_data   (dw_data),
        .load_en   (load_en),
        .load_data (load_data),
        .host_note (host_note),
        .stat_rel  (stat_release)
    );

    sync_tt_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load_en   (load_en),
        .load_data (load_data),
        .count     (tt_count)
    );

endmodule

// File: tb/test_sync_tt_loader.sv
`timescale 1ns/1ps
module test_sync_tt_loader;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr, cmd_stb, cmd_bcast, dw_stb, dw_err, tick;
    logic [1:0]  cfg_opt;
    logic [15:0] dw_data;
    logic [15:0] tt_count;
    logic        host_note, stat_release;

    int total = 0;
    int bad   = 0;
    logic [15:0] exp_cnt;

    always #2.5 clk = ~clk;

    sync_tt_loader i_sync_tt_loader (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_opt(cfg_opt),
        .cmd_stb(cmd_stb), .cmd_bcast(cmd_bcast), .dw_stb(dw_stb),
        .dw_err(dw_err), .dw_data(dw_data), .tick(tick),
        .tt_count(tt_count), .host_note(host_note), .stat_release(stat_release)
    );

    // {opt[1:0], bcast, err, word[15:0]}
    localparam logic [19:0] VEC [12] = '{
        {2'b11, 1'b0, 1'b0, 16'hA5A4},
        {2'b11, 1'b1, 1'b0, 16'h1235},
        {2'b01, 1'b0, 1'b0, 16'h0010},
        {2'b01, 1'b0, 1'b0, 16'h0011},
        {2'b10, 1'b0, 1'b0, 16'h0F0F},
        {2'b10, 1'b1, 1'b0, 16'h0F0E},
        {2'b00, 1'b0, 1'b0, 16'h7777},
        {2'b00, 1'b1, 1'b0, 16'h8888},
        {2'b11, 1'b0, 1'b1, 16'hDEAD},
        {2'b01, 1'b1, 1'b0, 16'h4440},
        {2'b10, 1'b0, 1'b1, 16'h3333},
        {2'b11, 1'b0, 1'b0, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string opt_tag(input logic [1:0] o);
        case (o)
            2'b11:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic logic decide(input logic [1:0] o, input logic [15:0] w);
        return (o == 2'b11) || (o == 2'b01 && !w[0]) || (o == 2'b10 && w[0]);
    endfunction

    task automatic write_opt(input logic [1:0] o);
        @(negedge clk); cfg_wr = 1'b1; cfg_opt = o;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic do_sync(input logic [1:0] o, input logic bc, input logic er,
                           input logic [15:0] w, input logic tk, input string tag);
        logic ld;
        ld = !er && decide(o, w);
        @(negedge clk); cmd_stb = 1'b1; cmd_bcast = bc;
        @(negedge clk); cmd_stb = 1'b0; cmd_bcast = 1'b0;
        dw_stb = 1'b1; dw_err = er; dw_data = w;
        @(negedge clk); dw_stb = 1'b0; dw_err = 1'b0;
        // cycle after validation
        chk({tag, " note R9"}, host_note, !er);
        chk({tag, " early release R6"}, stat_release, !er && !bc && !ld);
        chk({tag, " count before load R6"}, tt_count, exp_cnt);
        tick = tk;
        @(negedge clk); tick = 1'b0;
        if (ld) exp_cnt = w;
        else if (tk) exp_cnt = exp_cnt + 16'd1;
        chk({tag, " load release R6 R7"}, stat_release, !er && !bc && ld);
        chk({tag, " count R8"}, tt_count, exp_cnt);
        chk({tag, " note width R9"}, host_note, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wr = 0; cfg_opt = 0; cmd_stb = 0; cmd_bcast = 0;
        dw_stb = 0; dw_err = 0; dw_data = 0; tick = 0;
        exp_cnt = 16'h0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset count R10", tt_count, 16'h0000);
        chk("reset note R9", host_note, 1'b0);
        chk("reset release R6", stat_release, 1'b0);

        // R1: default option is 00 -> no load even with bit0 clear
        do_sync(2'b00, 1'b0, 1'b0, 16'h0002, 1'b0, "R1 default");

        for (int i = 0; i < 12; i++) begin
            write_opt(VEC[i][19:18]);
            do_sync(VEC[i][19:18], VEC[i][17], VEC[i][16], VEC[i][15:0], 1'b0,
                    VEC[i][16] ? "R8" : opt_tag(VEC[i][19:18]));
        end

        // R10: increment and wrap
        write_opt(2'b11);
        do_sync(2'b11, 1'b0, 1'b0, 16'hFFFE, 1'b0, "R10 preset");
        @(negedge clk); tick = 1'b1;
        @(negedge clk); chk("R10 inc", tt_count, 16'hFFFF);
        @(negedge clk); tick = 1'b0; chk("R10 wrap", tt_count, 16'h0000);
        @(negedge clk); chk("R10 hold", tt_count, 16'h0000);
        exp_cnt = 16'h0000;

        // R11: tick during the load cycle
        do_sync(2'b11, 1'b0, 1'b0, 16'h5A5A, 1'b1, "R11");
        // tick without load in the same window (option 00)
        write_opt(2'b00);
        do_sync(2'b00, 1'b0, 1'b0, 16'h1111, 1'b1, "R10 tick");

        // R1: reset returns option to 00 after writing 11
        write_opt(2'b11);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        exp_cnt = 16'h0000;
        do_sync(2'b00, 1'b0, 1'b0, 16'hBEEF, 1'b0, "R1 after reset");
        // R7: broadcast load with option 10
        write_opt(2'b10);
        do_sync(2'b10, 1'b1, 1'b0, 16'hC0C1, 1'b0, "R7 bcast");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule